// File: doc/BRIEF.md
# Dead-Time Compensating Current Feedback Predictor

This block sits in the feedback path of a digital current loop. It lets the PI controller see the expected effect of its own voltage command at once, rather than after the measurement dead time has passed. On every control sub-cycle strobe, which runs at twice the PWM carrier rate, the block does three things. It steps a discrete first-order resistor-inductor winding model driven by the voltage command. It pushes the model current into a short history line. It drives a corrected feedback current equal to the measured current, plus the present model current, minus the model current from D sub-cycles earlier. Back EMF is left out of the model because it changes slowly next to the current.

The added and subtracted model terms together form a correction pulse as long as the loop dead time. When the model is accurate, the dead time drops out of the command response. The two model coefficients are signed Q1.15 values captured from a configuration port. The history depth D is an elaboration parameter from 1 to 4.

Top module: `cur_pred_top`

## Requirements
- R1: A synchronous reset clears the model state, the history line, both coefficients, the corrected output and the valid flag to zero. After reset, the first strobe therefore outputs exactly the measured current.
- R2: On each strobe, the model state m is replaced by floor((a*m + b*v) / 2^15). Here a and b are the captured Q1.15 coefficients and v is the voltage command present at that strobe.
- R3: On each strobe, the output is i_meas + m[k] - m[k-D]. Here m[k] is the model state before that strobe's update, and m[k-D] is the state D strobes earlier (zero before D strobes have occurred).
- R4: fb_vld is high for exactly the one clock after each strobe. The output holds its value while no strobe occurs.
- R5: The output sum is saturated to the signed range of DW bits, from -2^(DW-1) to 2^(DW-1)-1.
- R6: The updated model state is saturated to the same signed DW-bit range.
- R7: Without a strobe, changes on v_cmd and i_meas do not alter the model state, the history or the output.
- R8: When cfg_ld is high at a clock edge, cfg_a and cfg_b are captured as the new coefficients. A strobe at the same edge still uses the previous coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd | input | 1 | Sub-cycle update strobe |
| cfg_ld | input | 1 | Coefficient capture enable |
| cfg_a | input | CW | Model feedback coefficient a, signed Q1.15 |
| cfg_b | input | CW | Model input coefficient b, signed Q1.15 |
| v_cmd | input | DW | Signed voltage command from the controller |
| i_meas | input | DW | Signed delayed current measurement |
| i_fb | output | DW | Corrected feedback current |
| fb_vld | output | 1 | High one clock after each strobe |

## Verification
The bench targets four corner cases.

- Pulse shape after a command step. A line with the wrong depth, or with the tap taken one stage off, would leave a permanent offset or cancel the correction early.
- Saturation at both ends of the output and model ranges. A design that wraps instead of clamping would flip the sign of the feedback.
- Strobe-free cycles where the inputs move. A design that lets the model free-run would drift.
- A coefficient load coinciding with a strobe. A design that forwards the new coefficients too early would give a different model sample on that strobe.

Random command, measurement, gap and coefficient sequences are compared against a bench model of the same recursion, including negative values, where floor rounding differs from truncation toward zero.

// File: rtl/cur_pred_pkg.sv
package cur_pred_pkg;

   localparam int unsigned MAX_DEPTH = 4;
   localparam int unsigned MAX_SUM_W = 62;

   // Clamp a wide signed value to the signed range of a w-bit word.
   function automatic longint clamp_to(input longint x, input int unsigned w);
      longint hi;
      longint lo;
      hi = (longint'(1) <<< (w - 1)) - 1;
      lo = -hi - 1;
      if (x > hi)      return hi;
      else if (x < lo) return lo;
      else             return x;
   endfunction

endpackage

// File: rtl/cur_pred_model.sv
module cur_pred_model
   import cur_pred_pkg::*;
#(
   parameter int unsigned DW = 16,
   parameter int unsigned CW = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 upd,
   input  logic                 cfg_ld,
   input  logic signed [CW-1:0] cfg_a,
   input  logic signed [CW-1:0] cfg_b,
   input  logic signed [DW-1:0] v_cmd,
   output logic signed [DW-1:0] m_now
);
   localparam int unsigned FRAC = CW - 1;

   logic signed [CW-1:0] coef_a_q;
   logic signed [CW-1:0] coef_b_q;
   logic signed [DW-1:0] m_q;
   logic signed [DW-1:0] m_d;
   longint               acc;

   always_comb begin
      acc = longint'(coef_a_q) * longint'(m_q) + longint'(coef_b_q) * longint'(v_cmd);
      m_d = DW'(clamp_to(acc >>> FRAC, DW));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         coef_a_q <= '0;
         coef_b_q <= '0;
      end else if (cfg_ld) begin
         coef_a_q <= cfg_a;
         coef_b_q <= cfg_b;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)      m_q <= '0;
      else if (upd) m_q <= m_d;
   end

   assign m_now = m_q;

   AST_COEF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      cfg_ld |=> (coef_a_q == $past(cfg_a) && coef_b_q == $past(cfg_b))); // R8
   AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(m_q)); // R7
   AST_ZERO_REST: assert property (@(posedge clk) disable iff (rst)
      (upd && m_q == '0 && v_cmd == '0) |=> (m_q == '0)); // R2

endmodule

// File: rtl/cur_pred_history.sv
module cur_pred_history #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 upd,
   input  logic signed [DW-1:0] din,
   output logic signed [DW-1:0] dout
);
   generate
      if (DEPTH == 1) begin : g_single
         logic signed [DW-1:0] tap_q;
         always_ff @(posedge clk) begin
            if (rst)      tap_q <= '0;
            else if (upd) tap_q <= din;
         end
         assign dout = tap_q;
         AST_TAP_LOAD: assert property (@(posedge clk) disable iff (rst)
            upd |=> (tap_q == $past(din))); // R3
      end else begin : g_chain
         logic signed [DW-1:0] taps [DEPTH];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
            end else if (upd) begin
               taps[0] <= din;
               for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
            end
         end
         assign dout = taps[DEPTH-1];
         for (genvar j = 1; j < DEPTH; j++) begin : g_chk
            AST_TAP_SHIFT: assert property (@(posedge clk) disable iff (rst)
               upd |=> (taps[j] == $past(taps[j-1]))); // R3
         end
      end
   endgenerate

endmodule

// File: rtl/cur_pred_combine.sv
module cur_pred_combine
   import cur_pred_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 upd,
   input  logic signed [DW-1:0] i_meas,
   input  logic signed [DW-1:0] m_now,
   input  logic signed [DW-1:0] m_old,
   output logic signed [DW-1:0] i_fb,
   output logic                 fb_vld
);
   longint               sum;
   logic signed [DW-1:0] fb_d;

   always_comb begin
      sum  = longint'(i_meas) + longint'(m_now) - longint'(m_old);
      fb_d = DW'(clamp_to(sum, DW));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         i_fb   <= '0;
         fb_vld <= 1'b0;
      end else begin
         fb_vld <= upd;
         if (upd) i_fb <= fb_d;
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(i_fb)); // R4
   AST_VLD_RISE: assert property (@(posedge clk) disable iff (rst)
      upd |=> fb_vld); // R4
   AST_VLD_LOW: assert property (@(posedge clk) disable iff (rst)
      !upd |=> !fb_vld); // R4

endmodule

// File: rtl/cur_pred_top.sv
module cur_pred_top
   import cur_pred_pkg::*;
#(
   parameter int unsigned DW    = 16,
   parameter int unsigned CW    = 16,
   parameter int unsigned DEPTH = 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 upd,
   input  logic                 cfg_ld,
   input  logic signed [CW-1:0] cfg_a,
   input  logic signed [CW-1:0] cfg_b,
   input  logic signed [DW-1:0] v_cmd,
   input  logic signed [DW-1:0] i_meas,
   output logic signed [DW-1:0] i_fb,
   output logic                 fb_vld
);
   initial begin
      assert (DEPTH >= 1 && DEPTH <= MAX_DEPTH)
         else $error("DEPTH must lie in 1..%0d", MAX_DEPTH);
      assert (DW >= 2 && CW >= 2 && DW + CW <= MAX_SUM_W)
         else $error("DW/CW out of supported range");
   end

   logic signed [DW-1:0] m_now;
   logic signed [DW-1:0] m_old;

   cur_pred_model #(.DW(DW), .CW(CW)) u_model (
      .clk(clk), .rst(rst), .upd(upd), .cfg_ld(cfg_ld),
      .cfg_a(cfg_a), .cfg_b(cfg_b), .v_cmd(v_cmd), .m_now(m_now)
   );

   cur_pred_history #(.DW(DW), .DEPTH(DEPTH)) u_hist (
      .clk(clk), .rst(rst), .upd(upd), .din(m_now), .dout(m_old)
   );

   cur_pred_combine #(.DW(DW)) u_comb (
      .clk(clk), .rst(rst), .upd(upd), .i_meas(i_meas),
      .m_now(m_now), .m_old(m_old), .i_fb(i_fb), .fb_vld(fb_vld)
   );

endmodule

// File: tb/cur_pred_top_bench.sv
module cur_pred_top_bench;
   localparam int BD = 3;

   logic clk = 0;
   logic rst = 1;
   logic upd = 0;
   logic cfg_ld = 0;
   logic signed [15:0] cfg_a = 0, cfg_b = 0, v_cmd = 0, i_meas = 0;
   logic signed [15:0] i_fb;
   logic fb_vld;

   int total = 0;
   int bad = 0;
   bit done = 0;

   longint bm, ba, bb;
   longint bdly [4];

   always #10 clk = ~clk;

   cur_pred_top #(.DW(16), .CW(16), .DEPTH(BD)) u_cur_pred_top (
      .clk(clk), .rst(rst), .upd(upd), .cfg_ld(cfg_ld), .cfg_a(cfg_a),
      .cfg_b(cfg_b), .v_cmd(v_cmd), .i_meas(i_meas), .i_fb(i_fb), .fb_vld(fb_vld)
   );

   function automatic longint sat16(input longint x);
      if (x > 32767) return 32767;
      if (x < -32768) return -32768;
      return x;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One strobe with optional coefficient load; checks output after one edge.
   task automatic strobe(input longint v, input longint m, input bit ld,
                         input longint na, input longint nb, input string req);
      longint exp;
      @(negedge clk);
      v_cmd = 16'(v); i_meas = 16'(m); upd = 1; cfg_ld = ld;
      cfg_a = 16'(na); cfg_b = 16'(nb);
      exp = sat16(m + bm - bdly[BD-1]);
      for (int i = 3; i > 0; i--) bdly[i] = bdly[i-1];
      bdly[0] = bm;
      bm = sat16((ba * bm + bb * v) >>> 15);
      if (ld) begin ba = na; bb = nb; end
      @(negedge clk);
      upd = 0; cfg_ld = 0;
      check({req, " out"}, longint'(i_fb), exp);
      check("R4 vld", longint'(fb_vld), 1);
   endtask

   // Cycles without a strobe while inputs wander.
   task automatic idle(input int n);
      logic signed [15:0] held;
      held = i_fb;
      for (int i = 0; i < n; i++) begin
         v_cmd = 16'($urandom); i_meas = 16'($urandom);
         @(negedge clk);
         check("R7 hold", longint'(i_fb), longint'(held));
         check("R4 vld low", longint'(fb_vld), 0);
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      bm = 0; ba = 0; bb = 0;
      for (int i = 0; i < 4; i++) bdly[i] = 0;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      check("R1 out", longint'(i_fb), 0);
      check("R1 vld", longint'(fb_vld), 0);
      strobe(5000, 1234, 0, 0, 0, "R1");
      idle(2);
      // load a=0.5, b=0.25 (Q1.15)
      strobe(0, 0, 1, 16384, 8192, "R8 load");
      // step: pulse correction of BD strobes
      for (int k = 0; k < 8; k++) strobe(8000, -300, 0, 0, 0, "R3 step");
      strobe(-8000, 100, 0, 0, 0, "R2 neg");
      idle(4);
      strobe(-7777, 55, 0, 0, 0, "R7 resume");
      // output saturation both ways
      strobe(30000, 32767, 0, 0, 0, "R5 hi");
      strobe(30000, 32767, 0, 0, 0, "R5 hi");
      strobe(-32768, -32768, 0, 0, 0, "R5 lo");
      for (int k = 0; k < 4; k++) strobe(-32768, -32768, 0, 0, 0, "R5 lo");
      // model saturation
      strobe(32767, 0, 1, 32767, 32767, "R8 same edge");
      for (int k = 0; k < 5; k++) strobe(32767, 0, 0, 0, 0, "R6 hi");
      strobe(-32768, 0, 1, 32767, -32768, "R8 same edge");
      for (int k = 0; k < 5; k++) strobe(32767, 0, 0, 0, 0, "R6 lo");
      // random mix
      for (int k = 0; k < 1500; k++) begin
         bit ld;
         ld = ($urandom % 16) == 0;
         strobe(longint'($signed(16'($urandom))), longint'($signed(16'($urandom))),
                ld, longint'($signed(16'($urandom))), longint'($signed(16'($urandom))),
                "R2 R3 rand");
         if (($urandom % 4) == 0) idle(1 + int'($urandom % 3));
      end
      // synchronous reset mid-run
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      bm = 0; ba = 0; bb = 0;
      for (int i = 0; i < 4; i++) bdly[i] = 0;
      check("R1 reset out", longint'(i_fb), 0);
      strobe(1000, -42, 0, 0, 0, "R1 after reset");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule